// File: doc/BRIEF.md
# Serial-In Latched Output Driver

This block turns a slow serial stream into a 10-bit parallel output word. Bits enter on a serial data pin and are clocked into a shift register on each rising edge of a serial clock pin. A bank of holding registers copies the shift register while a strobe pin is high and keeps its contents while the strobe is low. A blanking pin forces every parallel output low without touching what the holding registers store. The last shift stage is also driven out on a serial output pin, so several of these blocks can be chained into one longer register.

The four serial-side pins are asynchronous to the system clock. Each passes through a two-flop synchronizer, and the serial clock is edge-detected in the system clock domain. With the strobe held high the outputs ripple while data is being shifted, so the blanking pin is meant to hide the outputs during entry. Only logic states are modelled.

Top module: `shift_latch_driver`

## Requirements
- R1: A synchronous active-high reset clears the shift register and the holding registers, so `par_o` reads 0 and `ser_out_o` reads 0.
- R2: On a rising edge of `ser_clk_i`, the value on `ser_dat_i` (held steady around the edge) enters shift stage 0, which maps to `par_o[0]` once it is latched.
- R3: On each rising serial-clock edge, stage k takes the old value of stage k-1 for k from 1 to 9, so the bit shifted in first ends in stage 9 (`par_o[9]`) after 10 edges.
- R4: `ser_out_o` always shows the contents of the last shift stage (stage 9), whether or not the strobe is high.
- R5: While `strobe_i` is low, the holding registers keep their values, and `par_o` stays unchanged while shifting goes on.
- R6: While `strobe_i` is high, the holding registers follow the shift register, so `par_o` shows the shift contents a few system cycles after each change.
- R7: While `blank_i` is high, every bit of `par_o` is 0, whatever the holding registers contain and whatever shifting takes place.
- R8: Blanking does not alter the holding registers. When `blank_i` returns low, `par_o` shows the stored values again, including any values loaded under the strobe while blanked.
- R9: Only the low-to-high transition of `ser_clk_i` shifts. Holding the serial clock high or taking it low leaves the shift register unchanged, even when `ser_dat_i` changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk_i | input | 1 | Serial clock, asynchronous |
| ser_dat_i | input | 1 | Serial data in, asynchronous |
| strobe_i | input | 1 | Latch transparency control, asynchronous, active high |
| blank_i | input | 1 | Output blanking, asynchronous, active high |
| par_o | output | 10 | Parallel outputs, bit k from holding stage k |
| ser_out_o | output | 1 | Last shift stage, for chaining |

## Verification
The bound checker checks the following on every system cycle: the shift step and the capture of the delayed data bit on a detected edge, the shift register staying still when no edge is seen, the holding registers following or holding as the synchronized strobe selects, the zero output under blanking, the serial output tap, and the reset clear. The bench's scenarios drive the pins as real asynchronous inputs. They show what the cycle checks cannot: that a full 10-bit word arrives in the right order, that a word shifted under a low strobe stays hidden until the strobe rises, that values stored while blanked come back once blanking ends, and that a held or falling serial clock shifts nothing.

// File: rtl/sld_pkg.sv
package sld_pkg;
  // Grouping of the asynchronous pins as they pass through synchronization
  typedef struct packed {
    logic blank;
    logic strobe;
    logic sdat;
    logic sclk;
  } sld_pins_t;

  localparam int SLD_PIN_COUNT = $bits(sld_pins_t);
endpackage

// File: rtl/sld_sync.sv
module sld_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stg_q[g] <= '0;
          else     stg_q[g] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stg_q[g] <= '0;
          else     stg_q[g] <= stg_q[g-1];
        end
      end
    end
  endgenerate

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/sld_shift.sv
module sld_shift #(
  parameter int N = 10
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         shift_en,
  input  logic         din,
  output logic [N-1:0] sr_q
);
  // Stage 0 takes the new bit; stage k takes old stage k-1
  function automatic logic [N-1:0] advance(input logic [N-1:0] cur, input logic b);
    return {cur[N-2:0], b};
  endfunction

  always_ff @(posedge clk) begin
    if (rst)           sr_q <= '0;
    else if (shift_en) sr_q <= advance(sr_q, din);
  end
endmodule

// File: rtl/sld_latch.sv
module sld_latch #(
  parameter int N = 10
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_en,
  input  logic [N-1:0] d_i,
  input  logic         blank_i,
  output logic [N-1:0] latch_q,
  output logic [N-1:0] out_o
);
  function automatic logic [N-1:0] gate(input logic [N-1:0] v, input logic blank);
    return blank ? '0 : v;
  endfunction

  always_ff @(posedge clk) begin
    if (rst)          latch_q <= '0;
    else if (load_en) latch_q <= d_i;
  end

  assign out_o = gate(latch_q, blank_i);
endmodule

// File: rtl/shift_latch_driver.sv
module shift_latch_driver #(
  parameter int N           = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ser_clk_i,
  input  logic         ser_dat_i,
  input  logic         strobe_i,
  input  logic         blank_i,
  output logic [N-1:0] par_o,
  output logic         ser_out_o
);
  import sld_pkg::*;

  localparam int LAST = N - 1;

  sld_pins_t pins_raw, pins_s;
  logic      sclk_d;
  logic      data_d;
  logic      shift_fire;
  logic      s_strobe;
  logic      s_blank;
  logic [N-1:0] sr_q;
  logic [N-1:0] latch_q;

  assign pins_raw = '{blank: blank_i, strobe: strobe_i, sdat: ser_dat_i, sclk: ser_clk_i};

  sld_sync #(.W(SLD_PIN_COUNT), .STAGES(SYNC_STAGES)) sync_i (
    .clk (clk),
    .rst (rst),
    .d_i (pins_raw),
    .q_o (pins_s)
  );

  // Edge detect on serial clock; data delayed one cycle models setup
  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_d <= 1'b0;
      data_d <= 1'b0;
    end else begin
      sclk_d <= pins_s.sclk;
      data_d <= pins_s.sdat;
    end
  end

  assign shift_fire = pins_s.sclk & ~sclk_d;
  assign s_strobe   = pins_s.strobe;
  assign s_blank    = pins_s.blank;

  sld_shift #(.N(N)) shift_i (
    .clk      (clk),
    .rst      (rst),
    .shift_en (shift_fire),
    .din      (data_d),
    .sr_q     (sr_q)
  );

  sld_latch #(.N(N)) latch_i (
    .clk     (clk),
    .rst     (rst),
    .load_en (s_strobe),
    .d_i     (sr_q),
    .blank_i (s_blank),
    .latch_q (latch_q),
    .out_o   (par_o)
  );

  assign ser_out_o = sr_q[LAST];
endmodule

// File: rtl/sld_checker.sv
module sld_checker #(
  parameter int N = 10
) (
  input logic         clk,
  input logic         rst,
  input logic         shift_fire,
  input logic         data_d,
  input logic [N-1:0] sr_q,
  input logic [N-1:0] latch_q,
  input logic         s_strobe,
  input logic         s_blank,
  input logic [N-1:0] par_o,
  input logic         ser_out_o
);
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (sr_q == '0 && latch_q == '0));

  a_r2_capture: assert property (@(posedge clk) disable iff (rst)
    shift_fire |=> sr_q[0] == $past(data_d));

  a_r3_advance: assert property (@(posedge clk) disable iff (rst)
    shift_fire |=> sr_q[N-1:1] == $past(sr_q[N-2:0]));

  a_r4_tap: assert property (@(posedge clk) disable iff (rst)
    shift_fire |=> ser_out_o == $past(sr_q[N-2]));

  a_r5_hold: assert property (@(posedge clk) disable iff (rst)
    !s_strobe |=> $stable(latch_q));

  a_r6_follow: assert property (@(posedge clk) disable iff (rst)
    s_strobe |=> latch_q == $past(sr_q));

  a_r7_blank: assert property (@(posedge clk) disable iff (rst)
    s_blank |-> par_o == '0);

  a_r8_unblank: assert property (@(posedge clk) disable iff (rst)
    !s_blank |-> par_o == latch_q);

  a_r9_still: assert property (@(posedge clk) disable iff (rst)
    !shift_fire |=> $stable(sr_q));
endmodule

bind shift_latch_driver sld_checker #(.N(N)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .shift_fire (shift_fire),
  .data_d     (data_d),
  .sr_q       (sr_q),
  .latch_q    (latch_q),
  .s_strobe   (s_strobe),
  .s_blank    (s_blank),
  .par_o      (par_o),
  .ser_out_o  (ser_out_o)
);

// File: tb/shift_latch_driver_tb_top.sv
module shift_latch_driver_tb_top;
  localparam int N = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ser_clk = 1'b0, ser_dat = 1'b0, strobe = 1'b0, blank = 1'b0;
  logic [N-1:0] par;
  logic sout;

  always #10 clk = ~clk;

  shift_latch_driver #(.N(N)) dut_i (
    .clk (clk), .rst (rst), .ser_clk_i (ser_clk), .ser_dat_i (ser_dat),
    .strobe_i (strobe), .blank_i (blank), .par_o (par), .ser_out_o (sout)
  );

  typedef struct {
    logic [N-1:0] par;
    logic         sout;
    string        tag;
  } exp_t;

  exp_t q[$];
  event ev_sample;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  // Reference state
  logic [N-1:0] m_sr = '0, m_lat = '0;
  logic m_strobe = 1'b0, m_blank = 1'b0;

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_now(input string tag);
    exp_t e;
    e.par  = m_blank ? '0 : m_lat;
    e.sout = m_sr[N-1];
    e.tag  = tag;
    q.push_back(e);
    -> ev_sample;
    tick(1);
  endtask

  task automatic shift_bit(input logic b);
    ser_dat = b;
    tick(4);
    ser_clk = 1'b1;
    tick(6);
    ser_clk = 1'b0;
    tick(4);
    m_sr = {m_sr[N-2:0], b};
    if (m_strobe) m_lat = m_sr;
  endtask

  task automatic set_strobe(input logic v);
    strobe = v; m_strobe = v;
    tick(6);
    if (v) m_lat = m_sr;
  endtask

  task automatic set_blank(input logic v);
    blank = v; m_blank = v;
    tick(5);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    tick(4);
    rst = 1'b0;
    m_sr = '0; m_lat = '0;
    tick(2);
  endtask

  // Monitor: pop expected item and compare against the outputs
  initial begin
    forever begin
      @(ev_sample);
      if (q.size() != 0) begin
        exp_t e;
        e = q.pop_front();
        checks++;
        if (par !== e.par || sout !== e.sout) begin
          fails++;
          $display("FAIL %s: par=%b sout=%b expected par=%b sout=%b",
                   e.tag, par, sout, e.par, e.sout);
        end
      end
    end
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] word;
    word = 10'b1011001110;
    tick(3);
    do_reset();
    expect_now("R1 reset state");

    // R2: first captured bit lands in stage 0
    set_strobe(1'b1);
    shift_bit(1'b1);
    expect_now("R2 capture into stage 0");
    shift_bit(1'b0);
    shift_bit(1'b1);
    expect_now("R3 advance pattern 101");

    // R3/R4: full word, MSB first, checked after every shift
    for (int i = N - 1; i >= 0; i--) begin
      shift_bit(word[i]);
      expect_now("R4 serial tap during word entry");
    end
    expect_now("R3 full word in order");

    // R5: strobe low holds outputs while the shift register moves
    set_strobe(1'b0);
    shift_bit(1'b0);
    shift_bit(1'b1);
    shift_bit(1'b1);
    expect_now("R5 holding with strobe low");
    expect_now("R4 serial tap with strobe low");

    // R6: strobe high exposes the new contents
    set_strobe(1'b1);
    expect_now("R6 follow on strobe high");

    // R7: blanking zeroes outputs, including while shifting
    set_blank(1'b1);
    expect_now("R7 blank zeroes outputs");
    shift_bit(1'b1);
    shift_bit(1'b0);
    expect_now("R7 blank during shifting");

    // R8: values loaded while blanked appear on release
    set_blank(1'b0);
    expect_now("R8 unblank shows loaded values");
    set_strobe(1'b0);
    set_blank(1'b1);
    shift_bit(1'b1);
    expect_now("R7 blank with strobe low");
    set_blank(1'b0);
    expect_now("R8 unblank shows held values");

    // R9: only rising serial clock edges shift
    set_strobe(1'b1);
    ser_dat = 1'b0;
    tick(4);
    ser_clk = 1'b1;
    tick(6);
    m_sr = {m_sr[N-2:0], 1'b0};
    m_lat = m_sr;
    expect_now("R9 single shift on rising edge");
    ser_dat = 1'b1;
    tick(10);
    expect_now("R9 held high clock no shift");
    ser_clk = 1'b0;
    tick(10);
    expect_now("R9 falling edge no shift");
    ser_dat = 1'b0;

    // R1: reset mid-run
    do_reset();
    expect_now("R1 reset clears after use");

    tick(4);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule